// File: doc/BRIEF.md
# Word-to-Byte Bus Width Adapter

This block sits between a processor that only ever moves full 16-bit words on word-aligned addresses and a slower 8-bit peripheral bus. The processor presents just the upper 15 address bits and has no way to say which byte it wants. When the addressed region is one of the 8-bit regions, the adapter turns the single word access into two byte accesses in a row. It supplies the missing lowest address bit and holds the processor's ready line low until both bytes are done. Regions that live on the native 16-bit bus pass straight through with no added wait.

For a read, the byte from the even address is captured in a holding register while the odd byte is fetched. The two bytes are then handed to the processor as one word, with the even byte in the upper lane. For a write, the upper data lane goes out on the even byte cycle and the lower lane on the odd one. A byte store by the processor reaches an 8-bit region as a read of the whole word followed by a write of the whole word. The adapter serves each of those two word accesses in the same way.

The controller has four states. `ST_IDLE` waits for a request. `ST_EVEN` runs the even-byte cycle and `ST_ODD` runs the odd-byte cycle. `ST_DONE` presents the completed word. The transitions are as follows:
- start: `ST_IDLE` to `ST_EVEN`, on an enabled access to an 8-bit region.
- advance: `ST_EVEN` to `ST_ODD`, when the byte cycle timer has expired and the peripheral is ready.
- finish: `ST_ODD` to `ST_DONE`, on the same condition as advance.
- release: `ST_DONE` to `ST_IDLE`, once the peripheral is ready or the enable drops.
- abort: `ST_EVEN` or `ST_ODD` to `ST_IDLE`, when the enable drops.

Top module: `bus_width_adapter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `cpu_ready` is 1, `byte_en` is 0 and `byte_addr[0]` is 0.
- R2: An enabled access whose byte address lies outside the 8-bit window gets `wide_sel`=1 and `cpu_ready`=1 in the same cycle. It produces no byte cycle, and on a read `cpu_rdata` equals `wide_rdata`.
- R3: An enabled access to the 8-bit window keeps `cpu_ready` low for exactly 2*BYTE_CYCLES+1 rising edges, counted from the first edge at which the request is present. This holds when `byte_ready` stays high.
- R4: The even byte (`byte_addr[0]`=0) is transferred first for BYTE_CYCLES clocks, then the odd byte (`byte_addr[0]`=1) for BYTE_CYCLES clocks. `byte_addr[15:1]` always equals `cpu_addr`.
- R5: On a read from the 8-bit window, `cpu_rdata` in the ready cycle is {even byte, odd byte}, with the even byte in bits 15:8.
- R6: On a write to the 8-bit window, `byte_we` is 1 during both byte cycles. `byte_wdata` carries `cpu_wdata[15:8]` on the even byte and `cpu_wdata[7:0]` on the odd byte.
- R7: A byte cycle does not end while `byte_ready` is 0. With `byte_ready` held 0 for K edges from the start, the stall becomes 2*BYTE_CYCLES+1+max(0,K-BYTE_CYCLES).
- R8: While `cpu_memen` is 0, `byte_en` is 0. Dropping `cpu_memen` in the middle of a transfer ends it, and the next access starts from the even byte.
- R9: `byte_addr[0]` is 0 whenever no byte cycle is active.
- R10: The 8-bit window spans byte addresses NARROW_LO to NARROW_HI, with defaults 0x8400 and 0x9FFF. So 0x83FE and 0xA000 are 16-bit, while 0x8400 and 0x9FFE are 8-bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_addr | input | 15 | Word address from the processor (byte address bits 15:1) |
| cpu_memen | input | 1 | Memory access enable, high for the whole access |
| cpu_dbin | input | 1 | 1 = read, 0 = write |
| cpu_wdata | input | 16 | Write data word |
| cpu_rdata | output | 16 | Read data word to the processor |
| cpu_ready | output | 1 | Ready to the processor; 0 holds it |
| wide_sel | output | 1 | Access targets the native 16-bit bus |
| wide_rdata | input | 16 | Read data from the 16-bit bus |
| byte_addr | output | 16 | Byte address on the 8-bit bus, LSB generated here |
| byte_en | output | 1 | Byte cycle active |
| byte_we | output | 1 | Byte cycle is a write |
| byte_wdata | output | 8 | Byte write data |
| byte_rdata | input | 8 | Byte read data from the peripheral |
| byte_ready | input | 1 | Peripheral ready; 0 stretches the byte cycle |

## Verification
Two events can land on the same clock edge: the byte-cycle timer expiring and the peripheral pulling `byte_ready` low. This is provoked by holding `byte_ready` low across the point where the even phase would otherwise end. The result is judged by the exact stall count and by the assembled read word, which must still be correct. A second collision is the enable dropping while a phase is still counting. That case is judged by `byte_en` going low at once, and by the following access taking the full unshortened stall from the even byte.

// File: rtl/bwa_pkg.sv
package bwa_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EVEN = 2'd1,
        ST_ODD  = 2'd2,
        ST_DONE = 2'd3
    } bwa_state_e;

endpackage

// File: rtl/bwa_region_decode.sv
// Classifies the current word address as 8-bit window or native 16-bit bus.
module bwa_region_decode #(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] NARROW_LO = 16'h8400,
    parameter logic [ADDR_W-1:0] NARROW_HI = 16'h9FFF
) (
    input  logic [ADDR_W-2:0] word_addr,
    output logic              narrow
);
    logic [ADDR_W-1:0] even_addr;

    always_comb begin
        even_addr = {word_addr, 1'b0};
        narrow    = (even_addr >= NARROW_LO) && (even_addr <= NARROW_HI);
    end
endmodule

// File: rtl/bwa_phase_timer.sv
// Counts the clocks of one byte phase; saturates at the last count.
module bwa_phase_timer #(
    parameter int CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic last
);
    localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] TERM = CW'(CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (cnt_q != TERM) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last = (cnt_q == TERM);
endmodule

// File: rtl/bwa_byte_latch.sv
// Holds the even and odd bytes of a read and presents them as one word.
module bwa_byte_latch #(
    parameter int HALF_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cap_even,
    input  logic                cap_odd,
    input  logic [HALF_W-1:0]   din,
    output logic [2*HALF_W-1:0] word
);
    logic [HALF_W-1:0] even_q;
    logic [HALF_W-1:0] odd_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            even_q <= '0;
            odd_q  <= '0;
        end else begin
            if (cap_even) even_q <= din;
            if (cap_odd)  odd_q  <= din;
        end
    end

    assign word = {even_q, odd_q};
endmodule

// File: rtl/bwa_fsm.sv
// Sequencing of the two byte phases.
module bwa_fsm
    import bwa_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       memen,
    input  logic       narrow,
    input  logic       dbin,
    input  logic       byte_ready,
    input  logic       phase_last,
    output bwa_state_e state,
    output logic       timer_clear,
    output logic       cap_even,
    output logic       cap_odd,
    output logic       phase_active,
    output logic       odd_phase,
    output logic       word_done
);
    bwa_state_e state_q, state_d;
    logic       phase_end;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        phase_end = phase_last && byte_ready;
        state_d   = state_q;
        unique case (state_q)
            ST_IDLE: if (memen && narrow)              state_d = ST_EVEN;
            ST_EVEN: if (!memen)                       state_d = ST_IDLE;
                     else if (phase_end)               state_d = ST_ODD;
            ST_ODD:  if (!memen)                       state_d = ST_IDLE;
                     else if (phase_end)               state_d = ST_DONE;
            ST_DONE: if (!memen || byte_ready)         state_d = ST_IDLE;
            default:                                   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        timer_clear  = (state_d != state_q) || (state_q == ST_IDLE);
        cap_even     = (state_q == ST_EVEN) && memen && phase_end && dbin;
        cap_odd      = (state_q == ST_ODD)  && memen && phase_end && dbin;
        phase_active = memen && ((state_q == ST_EVEN) || (state_q == ST_ODD));
        odd_phase    = memen && (state_q == ST_ODD);
        word_done    = (state_q == ST_DONE);
    end

    assign state = state_q;
endmodule

// File: rtl/bus_width_adapter.sv
module bus_width_adapter
    import bwa_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 16,
    parameter int BYTE_CYCLES = 2,
    parameter logic [ADDR_W-1:0] NARROW_LO = 16'h8400,
    parameter logic [ADDR_W-1:0] NARROW_HI = 16'h9FFF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-2:0]   cpu_addr,
    input  logic                cpu_memen,
    input  logic                cpu_dbin,
    input  logic [DATA_W-1:0]   cpu_wdata,
    output logic [DATA_W-1:0]   cpu_rdata,
    output logic                cpu_ready,
    output logic                wide_sel,
    input  logic [DATA_W-1:0]   wide_rdata,
    output logic [ADDR_W-1:0]   byte_addr,
    output logic                byte_en,
    output logic                byte_we,
    output logic [DATA_W/2-1:0] byte_wdata,
    input  logic [DATA_W/2-1:0] byte_rdata,
    input  logic                byte_ready
);
    localparam int HALF_W = DATA_W / 2;

    logic              narrow;
    logic              phase_last;
    logic              timer_clear;
    logic              cap_even, cap_odd;
    logic              phase_active, odd_phase, word_done;
    logic [DATA_W-1:0] assembled;
    bwa_state_e        state;

    bwa_region_decode #(
        .ADDR_W(ADDR_W), .NARROW_LO(NARROW_LO), .NARROW_HI(NARROW_HI)
    ) u_decode (
        .word_addr(cpu_addr),
        .narrow   (narrow)
    );

    bwa_phase_timer #(.CYCLES(BYTE_CYCLES)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(timer_clear),
        .last (phase_last)
    );

    bwa_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .memen       (cpu_memen),
        .narrow      (narrow),
        .dbin        (cpu_dbin),
        .byte_ready  (byte_ready),
        .phase_last  (phase_last),
        .state       (state),
        .timer_clear (timer_clear),
        .cap_even    (cap_even),
        .cap_odd     (cap_odd),
        .phase_active(phase_active),
        .odd_phase   (odd_phase),
        .word_done   (word_done)
    );

    bwa_byte_latch #(.HALF_W(HALF_W)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_even(cap_even),
        .cap_odd (cap_odd),
        .din     (byte_rdata),
        .word    (assembled)
    );

    // Outputs towards the processor
    always_comb begin
        wide_sel = cpu_memen && !narrow;
        if (state == ST_IDLE) cpu_ready = !(cpu_memen && narrow);
        else                  cpu_ready = word_done && byte_ready;
        cpu_rdata = word_done ? assembled : wide_rdata;
    end

    // Outputs towards the byte bus
    always_comb begin
        byte_en    = phase_active;
        byte_we    = phase_active && !cpu_dbin;
        byte_addr  = {cpu_addr, odd_phase};
        byte_wdata = odd_phase ? cpu_wdata[HALF_W-1:0] : cpu_wdata[DATA_W-1:HALF_W];
    end
endmodule

// File: rtl/bwa_checker.sv
module bwa_checker (
    input logic clk,
    input logic rst_n,
    input logic cpu_memen,
    input logic cpu_dbin,
    input logic cpu_ready,
    input logic wide_sel,
    input logic byte_en,
    input logic byte_we,
    input logic byte_lsb
);
    a_r2_wide_no_wait: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_memen && wide_sel |-> cpu_ready && !byte_en);

    a_r3_hold_during_bytes: assert property (@(posedge clk) disable iff (!rst_n)
        byte_en |-> !cpu_ready);

    a_r4_even_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(byte_en) |-> !byte_lsb);

    a_r4_odd_after_even: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(byte_lsb) |-> $past(byte_en && !byte_lsb));

    a_r6_write_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        byte_we |-> byte_en && !cpu_dbin);

    a_r8_quiet_without_enable: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_memen |-> !byte_en);

    a_r9_lsb_rests_low: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_en |-> !byte_lsb);
endmodule

bind bus_width_adapter bwa_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_memen(cpu_memen),
    .cpu_dbin (cpu_dbin),
    .cpu_ready(cpu_ready),
    .wide_sel (wide_sel),
    .byte_en  (byte_en),
    .byte_we  (byte_we),
    .byte_lsb (byte_addr[0])
);

// File: tb/bus_width_adapter_tb.sv
`timescale 1ns/1ps
module bus_width_adapter_tb;
    localparam int N = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [14:0] cpu_addr = '0;
    logic        cpu_memen = 1'b0;
    logic        cpu_dbin = 1'b1;
    logic [15:0] cpu_wdata = '0;
    logic [15:0] cpu_rdata;
    logic        cpu_ready;
    logic        wide_sel;
    logic [15:0] wide_rdata;
    logic [15:0] byte_addr;
    logic        byte_en;
    logic        byte_we;
    logic [7:0]  byte_wdata;
    logic [7:0]  byte_rdata;
    logic        byte_ready = 1'b1;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    logic       log_lsb [64];
    logic       log_we  [64];
    logic [7:0] log_dat [64];

    always #2 clk = ~clk;

    assign wide_rdata = {cpu_addr, 1'b0} ^ 16'hA5C3;
    assign byte_rdata = byte_addr[7:0] ^ byte_addr[15:8] ^ 8'h3C;

    bus_width_adapter #(.BYTE_CYCLES(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_memen(cpu_memen),
        .cpu_dbin(cpu_dbin), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_ready(cpu_ready), .wide_sel(wide_sel), .wide_rdata(wide_rdata),
        .byte_addr(byte_addr), .byte_en(byte_en), .byte_we(byte_we),
        .byte_wdata(byte_wdata), .byte_rdata(byte_rdata), .byte_ready(byte_ready)
    );

    // addr(16) dbin(1) wdata(16)
    localparam logic [32:0] VEC [9] = '{
        {16'h0000, 1'b1, 16'h0000},
        {16'h83FE, 1'b1, 16'h0000},
        {16'h8400, 1'b1, 16'h0000},
        {16'h8800, 1'b0, 16'hBEEF},
        {16'h9C02, 1'b0, 16'h2000},
        {16'h9FFE, 1'b1, 16'h0000},
        {16'hA000, 1'b1, 16'h0000},
        {16'h2000, 1'b0, 16'h1234},
        {16'h9800, 1'b1, 16'h0000}
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pbyte(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction

    task automatic access(input logic [15:0] a, input logic d, input logic [15:0] wd,
                          input int hold_k, output logic [15:0] rd,
                          output int stall, output int nlog);
        int s;
        @(negedge clk);
        cpu_addr = a[15:1]; cpu_dbin = d; cpu_wdata = wd; cpu_memen = 1'b1;
        stall = 0; nlog = 0; s = 0; rd = '0;
        forever begin
            byte_ready = (s >= hold_k);
            #1;
            if (byte_en && nlog < 64) begin
                log_lsb[nlog] = byte_addr[0];
                log_we[nlog]  = byte_we;
                log_dat[nlog] = byte_wdata;
                nlog++;
            end
            if (cpu_ready) begin
                rd = cpu_rdata;
                break;
            end
            stall++; s++;
            if (stall > 60) break;
            @(negedge clk);
        end
        @(negedge clk);
        cpu_memen = 1'b0; byte_ready = 1'b1;
    endtask

    initial begin
        logic [15:0] rd;
        int stall, nlog;
        // R1 reset state
        repeat (3) @(negedge clk);
        check(cpu_ready === 1'b1, "R1 ready in reset", cpu_ready, 1);
        check(byte_en === 1'b0, "R1 byte_en in reset", byte_en, 0);
        check(byte_addr[0] === 1'b0, "R1 lsb in reset", byte_addr[0], 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(cpu_ready === 1'b1 && byte_en === 1'b0 && byte_addr[0] === 1'b0,
              "R1 after reset", {cpu_ready, byte_en, byte_addr[0]}, 3'b100);

        // Vector table: R2 R3 R4 R5 R6 R10
        for (int i = 0; i < 9; i++) begin
            logic [15:0] a;
            logic        d;
            logic [15:0] wd;
            bit          nar;
            a = VEC[i][32:17]; d = VEC[i][16]; wd = VEC[i][15:0];
            nar = (a >= 16'h8400) && (a <= 16'h9FFF);   // R10 window
            access(a, d, wd, 0, rd, stall, nlog);
            if (!nar) begin
                check(stall == 0, "R2/R10 wide stall", stall, 0);
                check(nlog == 0, "R2 no byte cycle", nlog, 0);
                if (d) check(rd == (a ^ 16'hA5C3), "R2 wide data", rd, a ^ 16'hA5C3);
            end else begin
                check(stall == 2*N+1, "R3/R10 narrow stall", stall, 2*N+1);
                check(nlog == 2*N, "R4 byte cycle count", nlog, 2*N);
                for (int j = 0; j < nlog && j < 2*N; j++) begin
                    check(log_lsb[j] == (j >= N), "R4 lsb order", log_lsb[j], (j >= N));
                    if (!d) begin
                        check(log_we[j] === 1'b1, "R6 write strobe", log_we[j], 1);
                        check(log_dat[j] == ((j >= N) ? wd[7:0] : wd[15:8]), "R6 lane",
                              log_dat[j], (j >= N) ? wd[7:0] : wd[15:8]);
                    end else begin
                        check(log_we[j] === 1'b0, "R5 no write on read", log_we[j], 0);
                    end
                end
                if (d) check(rd == {pbyte(a), pbyte(a | 16'h1)}, "R5 assembled word",
                             rd, {pbyte(a), pbyte(a | 16'h1)});
            end
        end

        // R7 peripheral not ready stretches the even phase
        access(16'h8A10, 1'b1, 16'h0, 5, rd, stall, nlog);
        check(stall == 2*N+1+(5-N), "R7 stretched stall", stall, 2*N+1+(5-N));
        check(rd == {pbyte(16'h8A10), pbyte(16'h8A11)}, "R7 data after stretch",
              rd, {pbyte(16'h8A10), pbyte(16'h8A11)});
        check(log_lsb[0] == 1'b0 && log_lsb[nlog-1] == 1'b1, "R7 R4 order kept",
              {log_lsb[0], log_lsb[nlog-1]}, 2'b01);

        // R8 R9 enable low with 8-bit address: nothing happens
        @(negedge clk);
        cpu_addr = 15'h4300; cpu_memen = 1'b0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check(byte_en === 1'b0, "R8 idle quiet", byte_en, 0);
            check(byte_addr[0] === 1'b0, "R9 lsb idle", byte_addr[0], 0);
        end

        // R8 abort mid transfer, then a full transfer from the even byte
        cpu_memen = 1'b1; cpu_dbin = 1'b1;
        @(negedge clk); @(negedge clk);
        check(byte_en === 1'b1, "R8 transfer started", byte_en, 1);
        cpu_memen = 1'b0;
        #1;
        check(byte_en === 1'b0, "R8 abort drops byte_en", byte_en, 0);
        check(byte_addr[0] === 1'b0, "R9 lsb after abort", byte_addr[0], 0);
        @(negedge clk);
        check(byte_en === 1'b0, "R8 stays idle", byte_en, 0);
        access(16'h8600, 1'b1, 16'h0, 0, rd, stall, nlog);
        check(stall == 2*N+1, "R8 full stall after abort", stall, 2*N+1);
        check(nlog > 0 && log_lsb[0] == 1'b0, "R8 restart from even", log_lsb[0], 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        finished = 1;
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule